// File: doc/BRIEF.md
# Dual Reload Timer

This block holds two 16-bit down-counting timer channels that share one clock prescaler. The system clock is divided by a programmable 8-bit prescaler to make a base tick. Each channel then thins that base tick through its own power-of-two divider tap. The result is the channel's count tick. Software loads a period into a channel's buffer register and copies it into the live counter with a manual-update command. It then starts the channel, either free-running with auto-reload or as a one-shot.

When a running channel is at zero and its count tick arrives, the channel raises a sticky pending flag, which is also driven on the `irq` output. With auto-reload set, the counter then refills from the buffer. A buffer value of B therefore gives a period of B+1 count ticks. The live count can be read at any time from a read-only observation register. Writing all zeros to the control register halts both channels.

Top module: `dual_reload_timer`

## Requirements
- R1: The base tick fires once every P+1 clock cycles, where P is the 8-bit field at bits 15:8 of address 0.
- R2: At address 1, bits 4n+1:4n hold the 2-bit divider code for channel n. With code c, the channel counts once every 2^(c+1) base ticks, so code 3 divides by 16.
- R3: While running, a channel's 16-bit counter steps down by one on each of its ticks. The buffer for channel n is at address 3+n, and a buffer value of 0xFFFF is held intact.
- R4: At address 2, writing 1 to bit 4n+1 (update) copies channel n's buffer into its counter in that cycle with no counting. The update bit always reads back as 0.
- R5: With start (bit 4n) and auto-reload (bit 4n+2) set, a tick at count 0 reloads the buffer. The channel keeps repeating with a period of (buffer+1) ticks.
- R6: Without auto-reload, a tick at count 0 leaves the count at 0 and clears the channel's start bit.
- R7: Every wrap through zero sets the channel's sticky pending bit, bit n of address 7, which is also driven on irq[n]. Both reset to 0.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the bit set.
- R9: Address 5+n returns channel n's live count. Writes to that address are ignored.
- R10: Writing 0 to address 2 stops both channels, and their counts then hold.
- R11: The observed count is never above the value last copied into that counter.
- R12: A stopped channel ignores its ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 2 | Per-channel pending flags |

## Verification
The assertions assume that each write lasts exactly one cycle and that the address is stable while the strobe is high. They also assume that nothing but this register bus changes the configuration. The bench drives the bus only at the falling clock edge and holds each write for one rising edge. The one exception is a deliberate two-cycle clear of the pending register, which is used to force a clear to coincide with a wrap. The per-cycle comparison against the reference model keeps a valid address on the bus at all times, so every read is defined.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  // control register layout, per channel stride
  localparam int CTL_STRIDE = 4;
  localparam int RUN_BIT    = 0;
  localparam int UPD_BIT    = 1;
  localparam int AR_BIT     = 2;
  // divider select stride and prescaler position
  localparam int SEL_STRIDE = 4;
  localparam int PRE_LSB    = 8;
  // fixed addresses
  localparam int A_PRE  = 0;
  localparam int A_DIV  = 1;
  localparam int A_CTRL = 2;
  localparam int A_BUF  = 3;
endpackage

// File: rtl/dtim_tickgen.sv
module dtim_tickgen #(
  parameter int PW  = 8,
  parameter int NCH = 2,
  parameter int SW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     pre_val,
  input  logic [NCH*SW-1:0] sel,
  output logic              pre_tick,
  output logic [NCH-1:0]    ch_tick
);
  localparam int DW = 1 << SW;

  logic [PW-1:0] pre_cnt, pre_cnt_nx;
  logic [DW-1:0] div_cnt, div_cnt_nx;

  always_comb begin
    pre_tick   = (pre_cnt >= pre_val);
    pre_cnt_nx = pre_tick ? '0 : pre_cnt + 1'b1;
    div_cnt_nx = pre_tick ? div_cnt + 1'b1 : div_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt_nx;
      div_cnt <= div_cnt_nx;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_tap
    logic [SW-1:0] code;
    logic [DW-1:0] tap;
    assign code = sel[g*SW +: SW];
    always_comb begin
      for (int b = 0; b < DW; b++) tap[b] = (b <= int'(code));
      ch_tick[g] = pre_tick && ((div_cnt & tap) == tap);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[g] |=> !ch_tick[g]);
  end

  // R1
  pre_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> (pre_tick == (pre_val == '0)));
endmodule

// File: rtl/dtim_chan.sv
module dtim_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctrl_wr,
  input  logic          wr_run,
  input  logic          wr_ar,
  input  logic          wr_upd,
  input  logic          pend_clr,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          ar_o,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q, cnt_nx, loaded_q, loaded_nx;
  logic          run_q, run_nx, ar_q, ar_nx, pend_q, pend_nx;
  logic          load, step, wrap;

  always_comb begin
    load      = ctrl_wr && wr_upd;
    step      = run_q && tick && !load;
    wrap      = step && (cnt_q == '0);
    cnt_nx    = cnt_q;
    loaded_nx = loaded_q;
    run_nx    = run_q;
    ar_nx     = ar_q;
    if (load) begin
      cnt_nx    = reload_val;
      loaded_nx = reload_val;
    end else if (wrap) begin
      if (ar_q) begin
        cnt_nx    = reload_val;
        loaded_nx = reload_val;
      end
    end else if (step) begin
      cnt_nx = cnt_q - 1'b1;
    end
    if (ctrl_wr) begin
      run_nx = wr_run;
      ar_nx  = wr_ar;
    end else if (wrap && !ar_q) begin
      run_nx = 1'b0;
    end
    pend_nx = wrap | (pend_q & ~pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= '0;
      run_q    <= 1'b0;
      ar_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      loaded_q <= loaded_nx;
      run_q    <= run_nx;
      ar_q     <= ar_nx;
      pend_q   <= pend_nx;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign ar_o   = ar_q;
  assign pend_o = pend_q;

  // R11
  cnt_le_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= loaded_q);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_upd) |=> cnt_q == $past(reload_val));
  // R5
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ar_q && tick && !load && cnt_q == '0) |=> cnt_q == $past(reload_val));
  // R6
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ar_q && tick && !ctrl_wr && cnt_q == '0) |=> !run_q);
  // R8
  wrap_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !load && cnt_q == '0) |=> pend_q);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(ctrl_wr && wr_upd)) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dtim_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CW     = 16,
  parameter int PW     = 8,
  parameter int SW     = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int A_OBS  = A_BUF + NCH;
  localparam int A_PEND = A_OBS + NCH;

  logic [PW-1:0]              pre_q, pre_nx;
  logic [NCH*SW-1:0]          sel_q, sel_nx;
  logic [NCH-1:0][CW-1:0]     buf_q, cnt_v;
  logic [NCH-1:0]             run_v, ar_v, pend_v, ch_tick;
  logic                       pre_tick;
  logic                       wr_pre, wr_div, wr_ctrl, wr_pend;

  always_comb begin
    wr_pre  = bus_wr && (bus_addr == ADDR_W'(A_PRE));
    wr_div  = bus_wr && (bus_addr == ADDR_W'(A_DIV));
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    wr_pend = bus_wr && (bus_addr == ADDR_W'(A_PEND));
    pre_nx  = wr_pre ? bus_wdata[PRE_LSB +: PW] : pre_q;
    sel_nx  = sel_q;
    if (wr_div)
      for (int n = 0; n < NCH; n++)
        sel_nx[n*SW +: SW] = bus_wdata[n*SEL_STRIDE +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sel_q <= '0;
    end else begin
      pre_q <= pre_nx;
      sel_q <= sel_nx;
    end
  end

  dtim_tickgen #(.PW(PW), .NCH(NCH), .SW(SW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_val  (pre_q),
    .sel      (sel_q),
    .pre_tick (pre_tick),
    .ch_tick  (ch_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          wr_buf;
    logic [CW-1:0] buf_nx;
    always_comb begin
      wr_buf = bus_wr && (bus_addr == ADDR_W'(A_BUF + g));
      buf_nx = wr_buf ? bus_wdata[CW-1:0] : buf_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[g] <= '0;
      else        buf_q[g] <= buf_nx;
    end

    dtim_chan #(.CW(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (ch_tick[g]),
      .ctrl_wr    (wr_ctrl),
      .wr_run     (bus_wdata[g*CTL_STRIDE + RUN_BIT]),
      .wr_ar      (bus_wdata[g*CTL_STRIDE + AR_BIT]),
      .wr_upd     (bus_wdata[g*CTL_STRIDE + UPD_BIT]),
      .pend_clr   (wr_pend && bus_wdata[g]),
      .reload_val (buf_q[g]),
      .cnt_o      (cnt_v[g]),
      .run_o      (run_v[g]),
      .ar_o       (ar_v[g]),
      .pend_o     (pend_v[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_PRE)) bus_rdata[PRE_LSB +: PW] = pre_q;
    if (bus_addr == ADDR_W'(A_DIV))
      for (int n = 0; n < NCH; n++) bus_rdata[n*SEL_STRIDE +: SW] = sel_q[n*SW +: SW];
    if (bus_addr == ADDR_W'(A_CTRL))
      for (int n = 0; n < NCH; n++) begin
        bus_rdata[n*CTL_STRIDE + RUN_BIT] = run_v[n];
        bus_rdata[n*CTL_STRIDE + AR_BIT]  = ar_v[n];
      end
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(A_BUF + n)) bus_rdata[CW-1:0] = buf_q[n];
      if (bus_addr == ADDR_W'(A_OBS + n)) bus_rdata[CW-1:0] = cnt_v[n];
    end
    if (bus_addr == ADDR_W'(A_PEND)) bus_rdata[NCH-1:0] = pend_v;
  end

  assign irq = pend_v;

  // R10
  stop_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata == '0) |=> run_v == '0);
  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend) |=> ((pend_v & $past(pend_v)) == $past(pend_v)));
endmodule

// File: tb/sim_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  always #10 clk = ~clk;

  dual_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit live  = 0;
  bit done  = 0;

  // behavioural reference
  int m_pre, m_pcnt, m_dcnt;
  int m_sel[2], m_buf[2], m_cnt[2], m_run[2], m_ar[2], m_pend[2];

  function automatic int m_read(int a);
    case (a)
      0: return m_pre << 8;
      1: return m_sel[0] | (m_sel[1] << 4);
      2: return m_run[0] | (m_ar[0] << 2) | (m_run[1] << 4) | (m_ar[1] << 6);
      3: return m_buf[0];
      4: return m_buf[1];
      5: return m_cnt[0];
      6: return m_cnt[1];
      default: return m_pend[0] | (m_pend[1] << 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_pcnt = 0; m_dcnt = 0;
      for (int c = 0; c < 2; c++) begin
        m_sel[c] = 0; m_buf[c] = 0; m_cnt[c] = 0;
        m_run[c] = 0; m_ar[c] = 0; m_pend[c] = 0;
      end
    end else begin
      int a, d, ptick, span;
      bit tk[2];
      a = int'(bus_addr);
      d = int'(bus_wdata);
      cyc++;
      ptick = (m_pcnt >= m_pre);
      for (int c = 0; c < 2; c++) begin
        span = 1 << (m_sel[c] + 1);
        tk[c] = ptick && ((m_dcnt + 1) % span == 0);
      end
      for (int c = 0; c < 2; c++) begin
        bit wrapped, halt;
        wrapped = 0; halt = 0;
        if (bus_wr && a == 2 && d[4*c+1]) m_cnt[c] = m_buf[c];
        else if (m_run[c] != 0 && tk[c]) begin
          if (m_cnt[c] == 0) begin
            wrapped = 1;
            if (m_ar[c] != 0) m_cnt[c] = m_buf[c];
            else halt = 1;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (bus_wr && a == 2) begin
          m_run[c] = d[4*c];
          m_ar[c]  = d[4*c+2];
        end else if (halt) m_run[c] = 0;
        if (wrapped) m_pend[c] = 1;
        else if (bus_wr && a == 7 && d[c]) m_pend[c] = 0;
      end
      if (ptick) begin
        m_pcnt = 0;
        m_dcnt = (m_dcnt + 1) % 16;
      end else m_pcnt = m_pcnt + 1;
      if (bus_wr && a == 0) m_pre = (d >> 8) & 255;
      if (bus_wr && a == 1) begin
        m_sel[0] = d & 3;
        m_sel[1] = (d >> 4) & 3;
      end
      if (bus_wr && a == 3) m_buf[0] = d & 16'hFFFF;
      if (bus_wr && a == 4) m_buf[1] = d & 16'hFFFF;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the reference
  always @(posedge clk) begin
    #5;
    if (live && !done) begin
      chk("R9/R11 live read vs model", int'(bus_rdata), m_read(int'(bus_addr)));
      chk("R7 irq vs model", int'(irq), m_pend[0] | (m_pend[1] << 1));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    bus_addr = a[2:0];
    @(posedge clk); #5;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic step_gap(int a, output int gap);
    int prev, t0;
    bus_addr = a[2:0];
    @(posedge clk); #5; prev = int'(bus_rdata);
    for (int i = 0; i < 2000 && int'(bus_rdata) == prev; i++) begin
      @(posedge clk); #5;
    end
    t0 = cyc; prev = int'(bus_rdata);
    for (int i = 0; i < 2000 && int'(bus_rdata) == prev; i++) begin
      @(posedge clk); #5;
    end
    gap = cyc - t0;
  endtask

  task automatic reload_time(int a, output int t);
    bus_addr = a[2:0];
    @(posedge clk); #5;
    for (int i = 0; i < 2000 && bus_rdata != 0; i++) begin @(posedge clk); #5; end
    for (int i = 0; i < 2000 && bus_rdata == 0; i++) begin @(posedge clk); #5; end
    t = cyc;
  endtask

  initial begin
    int g, t1, t2, s1, s2, v, mx;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;

    // reset state (R7)
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R7 reset register");
    chk("R7 reset irq", int'(irq), 0);

    // R4 manual update, R12 idle hold, R9 read-only
    wr(4, 'h1234);
    wr(2, 'h20);
    rd_chk(6, 'h1234, "R4 update copies buffer");
    rd_chk(2, 0, "R4 update bit reads 0");
    repeat (50) @(negedge clk);
    rd_chk(6, 'h1234, "R12 stopped count holds");
    wr(6, 0);
    rd_chk(6, 'h1234, "R9 write to observation ignored");

    // R1 prescaler, R2 divider taps
    wr(0, 3 << 8); wr(1, 0); wr(3, 100); wr(2, 7);
    step_gap(5, g); chk("R1 prescale 3, div2 step", g, 8);
    wr(1, 3);
    step_gap(5, g); chk("R2 prescale 3, div16 step", g, 64);
    wr(0, 0);
    step_gap(5, g); chk("R2 prescale 0, div16 step", g, 16);

    // R5 auto-reload period, R11 bound
    wr(1, 0); wr(3, 4); wr(2, 7);
    reload_time(5, t1);
    reload_time(5, t2);
    chk("R5 reload period", t2 - t1, 10);
    mx = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #5;
      if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
    end
    chk("R11 max observed count", mx, 4);

    // R8 clear colliding with wrap (buffer 0: wrap every tick, tick every 2 cycles)
    wr(3, 0); wr(2, 7);
    repeat (6) @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 1;
    @(posedge clk); #5; s1 = int'(irq[0]);
    @(posedge clk); #5; s2 = int'(irq[0]);
    @(negedge clk); bus_wr = 1'b0;
    chk("R8 wrap wins over clear", s1 + s2, 1);

    // R6 one-shot, R7 pending readout
    wr(2, 0); wr(7, 3);
    wr(4, 3); wr(2, 'h30);
    repeat (20) @(negedge clk);
    rd_chk(6, 0, "R6 one-shot ends at 0");
    rd_chk(2, 0, "R6 start bit cleared");
    rd_chk(7, 2, "R7 pending bit 1 set");
    chk("R7 irq reflects pending", int'(irq), 2);

    // R8 zero write, then clear
    wr(7, 0);
    rd_chk(7, 2, "R8 zero write keeps pending");
    wr(7, 2);
    rd_chk(7, 0, "R8 write one clears");

    // R10 stop all
    wr(3, 1000); wr(4, 1000); wr(2, 'h77);
    repeat (10) @(negedge clk);
    wr(2, 0);
    bus_addr = 3'd5;
    @(posedge clk); #5; v = int'(bus_rdata);
    repeat (40) @(negedge clk);
    rd_chk(5, v, "R10 count holds after stop");
    rd_chk(2, 0, "R10 control reads 0");

    // R3 full-width buffer
    wr(3, 'hFFFF); wr(2, 2);
    rd_chk(5, 'hFFFF, "R3 full-width load");
    wr(2, 5);
    repeat (20) @(negedge clk);
    bus_addr = 3'd5;
    @(posedge clk); #5; v = int'(bus_rdata);
    chk("R3 count from FFFF in range", int'(v >= 'hFFF3 && v <= 'hFFF6), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule